// File: doc/BRIEF.md
# Sine Tone PWM Synthesizer

This block produces a low-frequency signalling tone as a single-bit pulse-width-modulated stream. Downstream, an external low-pass filter turns it back into a sine wave. A frame counter gives every PWM frame the same fixed length. At the end of each frame a 24-bit phase register advances by a caller-supplied step word. The top byte of the phase addresses a sine sample table, and each sample is an amplitude centred on half the frame length.

The samples are double-buffered. A sample is read from the phase value that holds during one frame, and it is applied as the high-time of the frame after that. Every frame therefore has a stable duty. The output frequency is set only by the step word. With the default 200-tick frame, one step unit is worth 1/1600 of a hertz of tone, so the word equals the tone in hundredths of a hertz multiplied by 16. For example, 254.1 Hz needs a word of 406560, which gives at least 41 samples per sine cycle.

Top module: `tone_pwm_dds`

## Requirements
- R1: A frame is 200 enabled clock cycles long. `strobe_o` is high for exactly one cycle, the last cycle of each frame, and no two strobes are closer than 200 enabled cycles apart.
- R2: At each strobe the 24-bit phase becomes (phase + `tw_i`) mod 2^24. `tw_i` is sampled only in a strobe cycle, so changing it during any other cycle has no effect on the output.
- R3: The table address is phase bits 23..16, so a step below 65536 moves the address only when carries reach bit 16.
- R4: The table entry at address k equals floor(100 + 100*sin(2*pi*k/256) + 0.5). This gives 100 at address 0, 200 at address 64, 100 at address 128 and 0 at address 192.
- R5: Count frames from 1 after reset, and let f be the frame number. The high-time of frame 1 is 0. For f >= 2, the high-time is the table entry addressed by the phase held during frame f-1, which is (f-2)*`tw_i` mod 2^24 when the step word is constant.
- R6: While reset is high, and after it is released, the frame position, the phase and the duty are 0. `pwm_o` and `strobe_o` are low until the first strobe.
- R7: Within a frame, `pwm_o` is high exactly while the frame position is below the duty. A duty of 0 gives a frame that is all low, and a duty of 200 gives a frame that is all high.
- R8: While `en_i` is low, `pwm_o` and `strobe_o` are low and the frame position, phase and duty are frozen. On re-enable the frame resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low freezes the block and silences the output |
| tw_i | input | 24 | Phase step word, sampled at the frame strobe |
| pwm_o | output | 1 | PWM tone output |
| strobe_o | output | 1 | One-cycle pulse in the last cycle of each frame |

## Verification
The hardest condition to reach is a change of the step word that must have no effect. It is only visible several frames later, as the wrong high-time. The stimulus toggles `tw_i` away and back within a single frame. It then checks every following frame's high-time against the closed-form sequence computed from the frame number. A second hard case is pausing in the middle of a frame. The bench drops `en_i` partway through a frame and compares every cycle against a behavioural model, which confirms that the frame resumes with the same duty and the same position.

// File: rtl/tone_pwm_pkg.sv
package tone_pwm_pkg;

   // Rounded sine sample for a quarter-wave point j out of qn steps.
   function automatic int quarter_point(input int j, input int qn,
                                        input int off, input int amp);
      real ang;
      ang = 1.5707963267948966 * real'(j) / real'(qn);
      return $rtoi($floor(real'(off) + real'(amp) * $sin(ang) + 0.5));
   endfunction

   // Rounded sine sample for point i of a full wave of n steps.
   function automatic int full_point(input int i, input int n,
                                     input int off, input int amp);
      real ang;
      ang = 6.283185307179586 * real'(i) / real'(n);
      return $rtoi($floor(real'(off) + real'(amp) * $sin(ang) + 0.5));
   endfunction

endpackage

// File: rtl/tpd_frame_ctr.sv
module tpd_frame_ctr #(
   parameter int PERIOD = 200,
   parameter int CNT_W  = $clog2(PERIOD)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;

   assign wrap_o = en_i && (cnt_q == LAST);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       cnt_q <= '0;
      else if (wrap_o) cnt_q <= '0;
      else if (en_i)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/tpd_phase_acc.sv
module tpd_phase_acc #(
   parameter int ACC_W = 24
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             step_i,
   input  logic [ACC_W-1:0] tw_i,
   output logic [ACC_W-1:0] acc_o
);
   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       acc_q <= '0;
      else if (step_i) acc_q <= acc_q + tw_i;
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/tpd_sine_rom.sv
module tpd_sine_rom
   import tone_pwm_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int DUTY_W  = 8,
   parameter int OFFSET  = 100,
   parameter int AMP     = 100,
   parameter bit QUARTER = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [DUTY_W-1:0] sample_o
);
   localparam int NPTS = 1 << IDX_W;
   localparam int QN   = NPTS / 4;

   logic [DUTY_W-1:0] val;

   if (IDX_W < 3) begin : g_bad_idx
      $error("tpd_sine_rom: IDX_W must be at least 3");
   end

   if (QUARTER) begin : g_quarter
      logic [DUTY_W-1:0] qtab [0:QN];
      logic [1:0]        quad;
      logic [IDX_W-2:0]  qi;
      logic [DUTY_W-1:0] mag;

      for (genvar j = 0; j <= QN; j++) begin : g_pt
         assign qtab[j] = DUTY_W'(quarter_point(j, QN, OFFSET, AMP));
      end

      assign quad = idx_i[IDX_W-1 -: 2];
      always_comb begin
         qi  = quad[0] ? ((IDX_W-1)'(QN) - {1'b0, idx_i[IDX_W-3:0]})
                       : {1'b0, idx_i[IDX_W-3:0]};
         mag = qtab[qi];
         val = quad[1] ? (DUTY_W'(2 * OFFSET) - mag) : mag;
      end
   end else begin : g_full
      logic [DUTY_W-1:0] ftab [0:NPTS-1];
      for (genvar i = 0; i < NPTS; i++) begin : g_pt
         assign ftab[i] = DUTY_W'(full_point(i, NPTS, OFFSET, AMP));
      end
      assign val = ftab[idx_i];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) sample_o <= '0;
      else       sample_o <= val;
   end
endmodule

// File: rtl/tpd_pwm_stage.sv
module tpd_pwm_stage #(
   parameter int CNT_W  = 8,
   parameter int DUTY_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic              load_i,
   input  logic [DUTY_W-1:0] next_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [DUTY_W-1:0] duty_o,
   output logic              pwm_o
);
   logic [DUTY_W-1:0] duty_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       duty_q <= '0;
      else if (load_i) duty_q <= next_i;
   end

   assign duty_o = duty_q;
   assign pwm_o  = en_i && (32'(cnt_i) < 32'(duty_q));
endmodule

// File: rtl/tone_pwm_dds.sv
module tone_pwm_dds #(
   parameter int PERIOD  = 200,
   parameter int ACC_W   = 24,
   parameter int IDX_W   = 8,
   parameter int OFFSET  = 100,
   parameter int AMP     = 100,
   parameter bit QUARTER = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [ACC_W-1:0] tw_i,
   output logic             pwm_o,
   output logic             strobe_o
);
   localparam int CNT_W  = $clog2(PERIOD);
   localparam int DUTY_W = $clog2(PERIOD + 1);

   if (PERIOD < 2) begin : g_bad_period
      $error("tone_pwm_dds: PERIOD must be at least 2");
   end
   if (IDX_W > ACC_W) begin : g_bad_width
      $error("tone_pwm_dds: IDX_W exceeds ACC_W");
   end
   if (OFFSET < AMP || OFFSET + AMP > PERIOD) begin : g_bad_level
      $error("tone_pwm_dds: sample range must fit in 0..PERIOD");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [ACC_W-1:0]  acc_q;
   logic [DUTY_W-1:0] pend_q;
   logic [DUTY_W-1:0] duty_q;
   logic              wrap;

   tpd_frame_ctr #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_ctr (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
      .cnt_o(cnt_q), .wrap_o(wrap)
   );

   tpd_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk_i(clk_i), .rst_i(rst_i), .step_i(wrap),
      .tw_i(tw_i), .acc_o(acc_q)
   );

   tpd_sine_rom #(
      .IDX_W(IDX_W), .DUTY_W(DUTY_W), .OFFSET(OFFSET),
      .AMP(AMP), .QUARTER(QUARTER)
   ) u_rom (
      .clk_i(clk_i), .rst_i(rst_i),
      .idx_i(acc_q[ACC_W-1 -: IDX_W]), .sample_o(pend_q)
   );

   tpd_pwm_stage #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_pwm (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .load_i(wrap),
      .next_i(pend_q), .cnt_i(cnt_q), .duty_o(duty_q), .pwm_o(pwm_o)
   );

   assign strobe_o = wrap;
endmodule

module tone_pwm_dds_chk #(
   parameter int PERIOD = 200,
   parameter int ACC_W  = 24,
   parameter int CNT_W  = 8,
   parameter int DUTY_W = 8,
   parameter int OFFSET = 100,
   parameter int AMP    = 100
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              en_i,
   input logic [ACC_W-1:0]  tw_i,
   input logic              pwm_o,
   input logic              strobe_o,
   input logic [CNT_W-1:0]  cnt,
   input logic [ACC_W-1:0]  acc,
   input logic [DUTY_W-1:0] duty
);
   assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      32'(cnt) < PERIOD);
   assert_strobe_wrap_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_o |=> (cnt == '0));
   assert_acc_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_o |=> (acc == ACC_W'($past(acc) + $past(tw_i))));
   assert_acc_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !strobe_o |=> $stable(acc));
   assert_duty_range_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      32'(duty) <= OFFSET + AMP);
   assert_duty_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      !strobe_o |=> $stable(duty));
   assert_reset_clear_R6: assert property (@(posedge clk_i)
      rst_i |=> (acc == '0 && duty == '0 && cnt == '0));
   assert_zero_low_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (duty == '0) |-> !pwm_o);
   assert_full_high_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && 32'(duty) >= PERIOD) |-> pwm_o);
   assert_off_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |-> (!pwm_o && !strobe_o));
   assert_off_freeze_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> $stable(cnt));
endmodule

bind tone_pwm_dds tone_pwm_dds_chk #(
   .PERIOD(PERIOD), .ACC_W(ACC_W), .CNT_W(CNT_W), .DUTY_W(DUTY_W),
   .OFFSET(OFFSET), .AMP(AMP)
) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .tw_i(tw_i),
   .pwm_o(pwm_o), .strobe_o(strobe_o),
   .cnt(cnt_q), .acc(acc_q), .duty(duty_q)
);

// File: tb/tone_pwm_dds_test.sv
module tone_pwm_dds_test;
   localparam int FRAME = 200;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic [23:0] tw  = '0;
   logic        pwm, stb;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   tone_pwm_dds uut (
      .clk_i(clk), .rst_i(rst), .en_i(en), .tw_i(tw),
      .pwm_o(pwm), .strobe_o(stb)
   );

   always #4 clk = ~clk;

   function automatic int ref_sine(input longint k);
      real v;
      v = 100.0 + 100.0 * $sin(2.0 * 3.141592653589793 * real'(k) / 256.0);
      return int'($floor(v + 0.5));
   endfunction

   task automatic check(input bit ok, input string req, input longint act,
                        input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // Behavioural reference: frame position, phase and active duty.
   int     m_pos = 0, m_duty = 0;
   longint m_phase = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_pos = 0; m_phase = 0; m_duty = 0;
      end else if (en) begin
         if (m_pos == FRAME - 1) begin
            m_duty  = ref_sine(m_phase >> 16);
            m_phase = (m_phase + longint'(tw)) % 64'h1000000;
            m_pos   = 0;
         end else begin
            m_pos++;
         end
      end
   end

   // Per-cycle comparison plus closed-form frame high-time check.
   int    hi_cnt = 0, frame_no = 0;
   bit    closed_ok = 0;
   string tag = "R5";

   always @(posedge clk) begin
      #2;
      if (!done) begin
         bit e_pwm, e_stb;
         e_pwm = en && !rst && (m_pos < m_duty);
         e_stb = en && !rst && (m_pos == FRAME - 1);
         check(pwm == e_pwm, "R7 pwm level", pwm, e_pwm);
         check(stb == e_stb, "R1 strobe", stb, e_stb);
         if (rst) begin
            hi_cnt = 0; frame_no = 0;
         end else if (en) begin
            if (pwm) hi_cnt++;
            if (e_stb) begin
               frame_no++;
               if (closed_ok) begin
                  int exp_hi;
                  exp_hi = (frame_no == 1) ? 0 :
                     ref_sine(((longint'(frame_no - 2) * longint'(tw)) % 64'h1000000) >> 16);
                  check(hi_cnt == exp_hi, tag, hi_cnt, exp_hi);
               end
               hi_cnt = 0;
            end
         end
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart(input logic [23:0] w, input string t);
      @(negedge clk);
      rst = 1; en = 1; tw = w; closed_ok = 0;
      cycles(3);
      rst = 0; tag = t; closed_ok = 1;
   endtask

   initial begin
      // R6: outputs quiet in reset and through the first frame
      cycles(3);
      check(pwm == 0 && stb == 0, "R6 reset outputs", {pwm, stb}, 0);
      restart(24'd406560, "R5 254.1Hz frame high-time");
      cycles(100);
      check(pwm == 0, "R6 first frame low", pwm, 0);
      cycles(60 * FRAME);

      restart(24'd0, "R4 zero step gives mid level");
      cycles(5 * FRAME + 10);

      restart(24'h400000, "R4 R7 quarter steps 100/200/100/0");
      cycles(9 * FRAME + 10);

      restart(24'h00C000, "R3 sub-address step");
      cycles(12 * FRAME + 10);

      restart(24'hFF0000, "R2 wrap modulo 2^24");
      cycles(8 * FRAME + 10);

      // R2: step word wiggled between strobes must not matter
      restart(24'h400000, "R2 step ignored off strobe");
      cycles(50);
      tw = 24'h123456; cycles(40);
      tw = 24'h400000; cycles(FRAME + 30);
      tw = 24'h0; cycles(60);
      tw = 24'h400000; cycles(6 * FRAME);

      // R8: pause mid-frame; per-cycle model covers resume
      restart(24'h400000, "R8 pre-pause");
      cycles(2 * FRAME + 20);
      closed_ok = 0;
      en = 0;
      for (int i = 0; i < 50; i++) begin
         @(posedge clk); #2;
         check(pwm == 0 && stb == 0, "R8 quiet while disabled", {pwm, stb}, 0);
      end
      @(negedge clk);
      en = 1;
      cycles(4 * FRAME);
      // R8: after resuming, the frame with duty 200 should be full high
      check(n_bad == 0, "R8 resume matched model", n_bad, 0);

      finish_run();
   end

   initial begin
      #(200000 * 8);
      check(0, "watchdog", 0, 1);
      finish_run();
   end
endmodule